// File: doc/BRIEF.md
# UART Burst FIFO Access Port

This block sits between a host register bus and the receive and transmit byte FIFOs of a UART. It lets the host move data four bytes per bus access. It also lets the host read, in one word, everything it needs to decide how much to move. Two dword data windows are provided, one for each direction. A byte-wide data window serves remainders smaller than four bytes. A packed status word reports the receive fill level, the transmit free space, the interrupt state and the line-status flags.

The FIFOs themselves are outside the block. The receive side shows the block its fill level, a four-byte peek window at its head, and the error flags of the head byte. The block answers with a pop count for the current cycle. The transmit side shows its free space, and the block answers with a push count and the bytes to push. Multi-byte data is little-endian: the oldest byte sits in bits 7:0.

A host drains the receive FIFO by reading the status word and taking its low byte as the count. It then issues count/4 burst reads and finishes with byte reads. Transmission works the same way, using the free-space field. The sticky overrun flag is cleared by writing the clear code to the FIFO control offset.

Top module: `uart_burst_port`

## Requirements
- R1: After reset the overrun flag (status bit 25) is 0. With no bus access, `rx_pop_cnt` and `tx_push_cnt` are 0.
- R2: A status read at offset 0x9C returns the receive fill count in bits 7:0 and the transmit free count in bits 15:8.
- R3: Status bit 20 is 1 when `irq_pend` is low (no interrupt pending) and 0 when it is high.
- R4: Status bits 31:24 carry the line status. The head-byte error input is encoded {break, framing, parity}. Bit 24 is data-ready (fill count non-zero). Bit 26 is parity, bit 27 framing and bit 28 break, each shown only while the fill count is non-zero. Bit 31 is the OR of bits 26 to 28. Bit 29 is transmit-FIFO-empty (free count equals the depth). Bit 30 is bit 29 AND `tx_idle`. Bits 23:21 and 19:16 read 0.
- R5: A burst read at offset 0xA4 returns min(fill,4) head bytes little-endian, with the first byte in bits 7:0. The missing bytes read as zero. That same number of bytes is popped in that cycle.
- R6: A burst write at offset 0xA0 pushes min(free,4) bytes, taking the lowest bytes of the write data first. `tx_push_data` carries the write data.
- R7: A burst write with fewer than four free entries sets the overrun flag. The flag then stays set until it is cleared.
- R8: A byte read at offset 0x00 returns the head byte in bits 7:0 and pops one byte if the FIFO is non-empty. If the FIFO is empty it returns 0 and pops nothing. A byte write at 0x00 pushes data bits 7:0 when free space exists and otherwise pushes nothing, without touching the overrun flag.
- R9: Writing 0x43 in data bits 7:0 to offset 0x02 clears the overrun flag; other values leave it. When a set and a clear occur in the same cycle, the set wins.
- R10: A one-cycle pulse on `rx_ovr_evt` sets the overrun flag.
- R11: Status reads and accesses to unmapped offsets pop and push nothing. An unmapped read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_head_data | input | 32 | First four receive bytes, oldest in bits 7:0 |
| rx_head_err | input | 3 | Head byte errors {break, framing, parity} |
| rx_ovr_evt | input | 1 | Receive FIFO overflowed this cycle |
| rx_pop_cnt | output | 3 | Bytes to pop this cycle (0 to 4) |
| tx_free | input | CNT_W | Transmit FIFO free entries |
| tx_idle | input | 1 | Transmit shifter idle |
| tx_push_cnt | output | 3 | Bytes to push this cycle (0 to 4) |
| tx_push_data | output | 32 | Bytes to push, first in bits 7:0 |
| irq_pend | input | 1 | Interrupt pending from the interrupt logic |

## Verification
A table walks burst reads over fill levels from empty through one, two and three bytes up to more than four. This separates the byte masking and pop count at each partial level from the full-dword case. Paired with each read is a burst write at free levels from zero to full. These cases tell an exact push count apart from a clipped one, and a correctly raised overrun from a spurious one. Directed cases then separate head-error reporting with and without data present, check the clear code against a near-miss value and against a simultaneous set, and show that status and unmapped accesses leave both FIFOs untouched.

// File: rtl/uart_burst_pkg.sv
package uart_burst_pkg;

  localparam int unsigned BURST_BYTES = 4;

  localparam logic [7:0] OFS_BYTE = 8'h00;
  localparam logic [7:0] OFS_FCTL = 8'h02;
  localparam logic [7:0] OFS_STAT = 8'h9C;
  localparam logic [7:0] OFS_TXB  = 8'hA0;
  localparam logic [7:0] OFS_RXB  = 8'hA4;

  localparam logic [7:0] OVR_CLR_CODE = 8'h43;

  localparam int ST_NOIRQ  = 20;
  localparam int LS_DR     = 24;
  localparam int LS_OVR    = 25;
  localparam int LS_PAR    = 26;
  localparam int LS_FRM    = 27;
  localparam int LS_BRK    = 28;
  localparam int LS_THRE   = 29;
  localparam int LS_TEMT   = 30;
  localparam int LS_ERRANY = 31;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_BYTE, ACC_FCTL, ACC_STAT, ACC_TXB, ACC_RXB
  } acc_t;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  // Number of bytes one burst may move given the bytes available.
  function automatic logic [2:0] f_take(input logic [15:0] avail);
    return (avail >= 16'(BURST_BYTES)) ? 3'(BURST_BYTES) : avail[2:0];
  endfunction

  // Count field limited to eight bits.
  function automatic logic [7:0] f_sat8(input logic [15:0] v);
    return (v > 16'd255) ? 8'hFF : v[7:0];
  endfunction

  // Keep the lowest n bytes of a dword, zero the rest.
  function automatic logic [31:0] f_keep_bytes(input logic [31:0] d,
                                               input logic [2:0] n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < BURST_BYTES; i++) begin
      if (3'(i) < n) r[8*i +: 8] = d[8*i +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/ubp_addr_decode.sv
module ubp_addr_decode
  import uart_burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_t              rd_kind,
  output acc_t              wr_kind
);

  acc_t kind;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_BYTE)) kind = ACC_BYTE;
    else if (bus_addr == ADDR_W'(OFS_FCTL)) kind = ACC_FCTL;
    else if (bus_addr == ADDR_W'(OFS_STAT)) kind = ACC_STAT;
    else if (bus_addr == ADDR_W'(OFS_TXB))  kind = ACC_TXB;
    else if (bus_addr == ADDR_W'(OFS_RXB))  kind = ACC_RXB;
    else                                    kind = ACC_NONE;
  end

  assign rd_kind = bus_rd ? kind : ACC_NONE;
  assign wr_kind = bus_wr ? kind : ACC_NONE;

endmodule

// File: rtl/ubp_rx_unpack.sv
module ubp_rx_unpack
  import uart_burst_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_byte,
  input  logic             rd_burst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [31:0]      rx_head_data,
  output logic [2:0]       rx_pop_cnt,
  output logic [31:0]      rd_word
);

  logic [2:0] avail;
  logic       nonempty;

  assign avail    = f_take(16'(rx_count));
  assign nonempty = (rx_count != '0);

  always_comb begin
    rx_pop_cnt = 3'd0;
    if (rd_burst)     rx_pop_cnt = avail;
    else if (rd_byte) rx_pop_cnt = nonempty ? 3'd1 : 3'd0;
    rd_word = f_keep_bytes(rx_head_data, rx_pop_cnt);
  end

  // R5: never pop more than the FIFO holds, nor more than a dword
  p_pop_within_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (16'(rx_pop_cnt) <= 16'(rx_count)) && (rx_pop_cnt <= 3'd4));

  // R8: a byte access moves at most one byte
  p_byte_pop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte |-> (rx_pop_cnt <= 3'd1));

endmodule

// File: rtl/ubp_tx_pack.sv
module ubp_tx_pack
  import uart_burst_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte,
  input  logic             wr_burst,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] tx_free,
  output logic [2:0]       tx_push_cnt,
  output logic [31:0]      tx_push_data,
  output logic             drop_evt
);

  logic [2:0] room;

  assign room = f_take(16'(tx_free));

  always_comb begin
    tx_push_cnt  = 3'd0;
    tx_push_data = '0;
    drop_evt     = 1'b0;
    if (wr_burst) begin
      tx_push_cnt  = room;
      tx_push_data = wdata;
      drop_evt     = (room != 3'(BURST_BYTES));
    end else if (wr_byte) begin
      tx_push_cnt  = (tx_free != '0) ? 3'd1 : 3'd0;
      tx_push_data = {24'd0, wdata[7:0]};
    end
  end

  // R6: never push beyond the free space
  p_push_within_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    16'(tx_push_cnt) <= 16'(tx_free));

  // R7: a drop only happens on a burst that could not fit
  p_drop_only_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (wr_burst && (tx_push_cnt < 3'd4)));

endmodule

// File: rtl/ubp_line_status.sv
module ubp_line_status
  import uart_burst_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_set_ext,
  input  logic             ovr_set_drop,
  input  logic             ovr_clr,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_free,
  input  rx_err_t          head_err,
  input  logic             irq_pend,
  input  logic             tx_idle,
  output logic [31:0]      status_word
);

  logic ovr_q;
  logic ovr_set;
  logic has_data;
  logic thre;

  assign ovr_set  = ovr_set_ext | ovr_set_drop;
  assign has_data = (rx_count != '0);
  assign thre     = (tx_free == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_set) ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  always_comb begin
    status_word            = '0;
    status_word[7:0]       = f_sat8(16'(rx_count));
    status_word[15:8]      = f_sat8(16'(tx_free));
    status_word[ST_NOIRQ]  = ~irq_pend;
    status_word[LS_DR]     = has_data;
    status_word[LS_OVR]    = ovr_q;
    status_word[LS_PAR]    = has_data & head_err.par;
    status_word[LS_FRM]    = has_data & head_err.frm;
    status_word[LS_BRK]    = has_data & head_err.brk;
    status_word[LS_THRE]   = thre;
    status_word[LS_TEMT]   = thre & tx_idle;
    status_word[LS_ERRANY] = has_data & (|head_err);
  end

  // R7: a dropped burst byte raises the overrun bit next cycle
  p_drop_sets_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set_drop |=> status_word[LS_OVR]);

  // R7: the flag is sticky without a set or clear
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_set && !ovr_clr) |=> $stable(status_word[LS_OVR]));

  // R9: a clear without a set drops the flag
  p_clear_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !ovr_set) |=> !status_word[LS_OVR]);

  // R10: an external overrun raises the flag
  p_ext_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set_ext |=> status_word[LS_OVR]);

  // R4: error bits never show while the FIFO is empty
  p_err_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data |-> (status_word[LS_ERRANY:LS_DR] & 8'b1001_1101) == 8'd0);

endmodule

// File: rtl/uart_burst_port.sv
module uart_burst_port
  import uart_burst_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [31:0]       rx_head_data,
  input  logic [2:0]        rx_head_err,
  input  logic              rx_ovr_evt,
  output logic [2:0]        rx_pop_cnt,
  input  logic [CNT_W-1:0]  tx_free,
  input  logic              tx_idle,
  output logic [2:0]        tx_push_cnt,
  output logic [31:0]       tx_push_data,
  input  logic              irq_pend
);

  acc_t        rd_kind;
  acc_t        wr_kind;
  logic [31:0] rd_word;
  logic [31:0] status_word;
  logic        drop_evt;
  logic        ovr_clr;

  ubp_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rd_kind (rd_kind),
    .wr_kind (wr_kind)
  );

  ubp_rx_unpack #(.CNT_W(CNT_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_byte     (rd_kind == ACC_BYTE),
    .rd_burst    (rd_kind == ACC_RXB),
    .rx_count    (rx_count),
    .rx_head_data(rx_head_data),
    .rx_pop_cnt  (rx_pop_cnt),
    .rd_word     (rd_word)
  );

  ubp_tx_pack #(.CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_byte     (wr_kind == ACC_BYTE),
    .wr_burst    (wr_kind == ACC_TXB),
    .wdata       (bus_wdata),
    .tx_free     (tx_free),
    .tx_push_cnt (tx_push_cnt),
    .tx_push_data(tx_push_data),
    .drop_evt    (drop_evt)
  );

  assign ovr_clr = (wr_kind == ACC_FCTL) && (bus_wdata[7:0] == OVR_CLR_CODE);

  ubp_line_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ls (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovr_set_ext (rx_ovr_evt),
    .ovr_set_drop(drop_evt),
    .ovr_clr     (ovr_clr),
    .rx_count    (rx_count),
    .tx_free     (tx_free),
    .head_err    (rx_err_t'(rx_head_err)),
    .irq_pend    (irq_pend),
    .tx_idle     (tx_idle),
    .status_word (status_word)
  );

  always_comb begin
    unique case (rd_kind)
      ACC_BYTE, ACC_RXB: bus_rdata = rd_word;
      ACC_STAT:          bus_rdata = status_word;
      default:           bus_rdata = '0;
    endcase
  end

  // R11: reads other than the data windows never pop
  p_no_pop_elsewhere_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_kind != ACC_BYTE && rd_kind != ACC_RXB) |-> (rx_pop_cnt == 3'd0));

  // R11: writes other than the data windows never push
  p_no_push_elsewhere_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind != ACC_BYTE && wr_kind != ACC_TXB) |-> (tx_push_cnt == 3'd0));

endmodule

// File: tb/uart_burst_port_bench.sv
module uart_burst_port_bench;

  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [31:0] HEAD = 32'hD4C3B2A1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [CNT_W-1:0]  rx_count = '0;
  logic [31:0]       rx_head_data = HEAD;
  logic [2:0]        rx_head_err = '0;
  logic              rx_ovr_evt = 1'b0;
  logic [2:0]        rx_pop_cnt;
  logic [CNT_W-1:0]  tx_free = CNT_W'(DEPTH);
  logic              tx_idle = 1'b1;
  logic [2:0]        tx_push_cnt;
  logic [31:0]       tx_push_data;
  logic              irq_pend = 1'b0;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  uart_burst_port #(.DEPTH(DEPTH), .ADDR_W(8)) u_uart_burst_port (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_count(rx_count), .rx_head_data(rx_head_data),
    .rx_head_err(rx_head_err), .rx_ovr_evt(rx_ovr_evt),
    .rx_pop_cnt(rx_pop_cnt), .tx_free(tx_free), .tx_idle(tx_idle),
    .tx_push_cnt(tx_push_cnt), .tx_push_data(tx_push_data),
    .irq_pend(irq_pend)
  );

  // rows: {rx fill, tx free, expected burst read word}
  localparam logic [43:0] VEC [0:7] = '{
    {4'd0, 8'd64, 32'h0000_0000},
    {4'd1, 8'd5,  32'h0000_00A1},
    {4'd2, 8'd4,  32'h0000_B2A1},
    {4'd3, 8'd3,  32'h00C3_B2A1},
    {4'd4, 8'd1,  32'hD4C3_B2A1},
    {4'd5, 8'd0,  32'hD4C3_B2A1},
    {4'd6, 8'd2,  32'hD4C3_B2A1},
    {4'd4, 8'd64, 32'hD4C3_B2A1}
  };

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read: drive at negedge, sample before the next edge, release after it
  task automatic do_rd(input logic [7:0] a, output logic [31:0] d,
                       output logic [2:0] pc);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2;
    d = bus_rdata; pc = rx_pop_cnt;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] w,
                       output logic [2:0] pc, output logic [31:0] pd);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
    #2;
    pc = tx_push_cnt; pd = tx_push_data;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  function automatic logic [2:0] min4(input int v);
    return (v > 4) ? 3'd4 : 3'(v);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pd;
    logic [2:0]  pc;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    #2;
    chk("R1 pop idle", 32'(rx_pop_cnt), 32'd0);
    chk("R1 push idle", 32'(tx_push_cnt), 32'd0);
    do_rd(8'h9C, d, pc);
    chk("R1 status after reset", d, 32'h6010_4000);
    chk("R1 overrun clear", 32'(d[25]), 32'd0);

    // R5 R6 R7 R9: vector table
    for (int i = 0; i < 8; i++) begin
      logic [3:0]  fill;
      logic [7:0]  free;
      logic [31:0] exp_rd;
      {fill, free, exp_rd} = VEC[i];
      rx_count = CNT_W'(fill);
      tx_free  = CNT_W'(free);
      do_rd(8'hA4, d, pc);
      chk("R5 burst read data", d, exp_rd);
      chk("R5 burst pop count", 32'(pc), 32'(min4(int'(fill))));
      do_wr(8'hA0, 32'h4433_2211, pc, pd);
      chk("R6 burst push count", 32'(pc), 32'(min4(int'(free))));
      chk("R6 burst push data", pd, 32'h4433_2211);
      do_rd(8'h9C, d, pc);
      chk("R7 overrun on short space", 32'(d[25]), 32'(free < 8'd4));
      do_wr(8'h02, 32'h43, pc, pd);
      do_rd(8'h9C, d, pc);
      chk("R9 overrun cleared", 32'(d[25]), 32'd0);
    end

    // R2: count fields
    rx_count = CNT_W'(37); tx_free = CNT_W'(9);
    do_rd(8'h9C, d, pc);
    chk("R2 rx count field", 32'(d[7:0]), 32'd37);
    chk("R2 tx free field", 32'(d[15:8]), 32'd9);

    // R3: interrupt flag
    irq_pend = 1'b1;
    do_rd(8'h9C, d, pc);
    chk("R3 pending gives 0", 32'(d[20]), 32'd0);
    irq_pend = 1'b0;
    do_rd(8'h9C, d, pc);
    chk("R3 idle gives 1", 32'(d[20]), 32'd1);

    // R4: line status
    rx_count = CNT_W'(3); rx_head_err = 3'b010; tx_free = CNT_W'(10);
    do_rd(8'h9C, d, pc);
    chk("R4 framing with data", 32'(d[31:24]), 32'h89);
    chk("R4 reserved bits", 32'({d[23:21], d[19:16]}), 32'd0);
    rx_head_err = 3'b101;
    do_rd(8'h9C, d, pc);
    chk("R4 parity and break", 32'(d[31:24]), 32'h95);
    rx_count = '0;
    do_rd(8'h9C, d, pc);
    chk("R4 errors hidden when empty", 32'(d[31:24]), 32'h00);
    rx_head_err = '0; tx_free = CNT_W'(DEPTH); tx_idle = 1'b0;
    do_rd(8'h9C, d, pc);
    chk("R4 empty tx shifter busy", 32'(d[31:24]), 32'h20);
    tx_idle = 1'b1;
    do_rd(8'h9C, d, pc);
    chk("R4 empty tx shifter idle", 32'(d[31:24]), 32'h60);

    // R8: byte port
    rx_count = CNT_W'(2);
    do_rd(8'h00, d, pc);
    chk("R8 byte read data", d, 32'h0000_00A1);
    chk("R8 byte read pop", 32'(pc), 32'd1);
    rx_count = '0;
    do_rd(8'h00, d, pc);
    chk("R8 empty byte read data", d, 32'd0);
    chk("R8 empty byte read pop", 32'(pc), 32'd0);
    tx_free = CNT_W'(1);
    do_wr(8'h00, 32'hFFFF_FF5A, pc, pd);
    chk("R8 byte write push", 32'(pc), 32'd1);
    chk("R8 byte write data", pd, 32'h0000_005A);
    tx_free = '0;
    do_wr(8'h00, 32'h77, pc, pd);
    chk("R8 byte write full push", 32'(pc), 32'd0);
    do_rd(8'h9C, d, pc);
    chk("R8 full byte write no overrun", 32'(d[25]), 32'd0);

    // R7 R9: clear code, near miss, and set beating clear
    do_wr(8'hA0, 32'h1, pc, pd);
    do_wr(8'h02, 32'h42, pc, pd);
    do_rd(8'h9C, d, pc);
    chk("R9 wrong code keeps overrun", 32'(d[25]), 32'd1);
    do_rd(8'h9C, d, pc);
    chk("R7 overrun sticky", 32'(d[25]), 32'd1);
    @(negedge clk);
    rx_ovr_evt = 1'b1; bus_wr = 1'b1; bus_addr = 8'h02; bus_wdata = 32'h43;
    @(posedge clk); #1;
    bus_wr = 1'b0; rx_ovr_evt = 1'b0;
    do_rd(8'h9C, d, pc);
    chk("R9 set wins over clear", 32'(d[25]), 32'd1);
    do_wr(8'h02, 32'h43, pc, pd);
    do_rd(8'h9C, d, pc);
    chk("R9 clear alone", 32'(d[25]), 32'd0);

    // R10: external overrun pulse
    @(negedge clk); rx_ovr_evt = 1'b1;
    @(negedge clk); rx_ovr_evt = 1'b0;
    do_rd(8'h9C, d, pc);
    chk("R10 external overrun", 32'(d[25]), 32'd1);
    do_wr(8'h02, 32'h43, pc, pd);

    // R11: no side effects
    rx_count = CNT_W'(5); tx_free = CNT_W'(DEPTH);
    do_rd(8'h9C, d, pc);
    chk("R11 status read no pop", 32'(pc), 32'd0);
    do_rd(8'h50, d, pc);
    chk("R11 unmapped read data", d, 32'd0);
    chk("R11 unmapped read no pop", 32'(pc), 32'd0);
    do_wr(8'h50, 32'hAABB_CCDD, pc, pd);
    chk("R11 unmapped write no push", 32'(pc), 32'd0);
    do_wr(8'h9C, 32'hAABB_CCDD, pc, pd);
    chk("R11 status write no push", 32'(pc), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule